// File: doc/BRIEF.md
# DRAM Start-up and Self-Refresh Sequencer

This block drives the row and column strobes of an asynchronous EDO DRAM during the two phases in which no ordinary access may run. The first phase is bring-up after reset, and the second is low-power retention. After reset the sequencer keeps both strobes high for a long power-up pause. It then runs a fixed number of dummy refresh cycles, each with the column strobe falling before the row strobe. Only after the last of these cycles and its precharge does it raise `ready`, which tells the rest of the memory controller that normal traffic may start.

While `ready` is high, a sleep request puts the memory into self refresh. The column strobe drops first and the row strobe follows one clock later. Both strobes are then held low for at least the minimum retention time. A wake request releases both strobes together. The block then waits out the self-refresh precharge before it raises `ready` again.

Every minimum time is given in nanoseconds as a parameter. Each is converted to a whole number of clock cycles by rounding up against the clock-period parameter.

Top module: `dram_sleep_seq`

## Requirements
- R1: During reset and throughout the power-up pause, `rasN` and `casN` are 1 and `ready` and `sleeping` are 0.
- R2: After the pause, exactly INIT_CYCLES refresh cycles run. In each, `casN` falls one clock before `rasN`, `rasN` stays low for the refresh-low count, and then both strobes stay high for the refresh-precharge count.
- R3: `ready` rises in the clock after the last precharge of initialization. While `ready` is 1, both strobes are 1.
- R4: `sleepReq` has no effect while `ready` is 0, and `wakeReq` has no effect while `ready` is 1. In both cases the outputs follow the schedule they would follow without the request.
- R5: A `sleepReq` seen while `ready` is 1 drops `casN` and `ready` on the next clock. `rasN` drops one clock after that, and from that point `sleeping` is 1.
- R6: In self refresh, `rasN` stays low for at least the self-refresh-low count of clocks.
- R7: A `wakeReq` pulse that arrives before the minimum self-refresh time has run out is remembered. Exit then happens exactly when the minimum time ends, so `rasN` is low for exactly that count.
- R8: On exit, `rasN` and `casN` rise on the same clock and `sleeping` falls. `ready` stays 0 for the self-refresh-precharge count of clocks and then returns to 1.
- R9: Each count equals the nanosecond parameter divided by CLK_PERIOD_NS, rounded up. The power-up pause lasts that many full clocks after reset release, before `casN` first falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Request to enter self refresh (acted on while ready) |
| wakeReq | input | 1 | Request to leave self refresh (a pulse is enough) |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| ready | output | 1 | High when normal accesses may be issued |
| sleeping | output | 1 | High while the DRAM is held in self refresh |

## Verification
The embedded properties assume that `sleepReq` and `wakeReq` change only between clock edges. They also assume that a wake pulse may arrive at any point in self refresh, including long before the minimum time has run out. The stimulus changes every input shortly after the falling clock edge. It raises requests while they must be ignored: a sleep request during the pause and a wake request while ready. It also sends one wake pulse early and one late, so that both the pending-wake path and the direct exit are exercised.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_INIT_CAS, ST_INIT_RAS, ST_INIT_PRE,
    ST_READY, ST_ENT_CAS, ST_SELF, ST_EXIT
  } seq_state_e;

  typedef enum logic [2:0] {
    DUR_ONE, DUR_REF_LOW, DUR_REF_PRE, DUR_SELF_LOW, DUR_SELF_PRE
  } dur_sel_e;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic     load;      // reload the interval counter
    dur_sel_e durSel;    // which interval to load
    logic     initStep;  // one initialization cycle finished
    logic     initClr;   // restart the initialization tally
    logic     wakeArm;   // wake requests may be latched
    logic     wakeClr;   // drop a latched wake request
  } seq_strobe_t;

  // Nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer
  import dram_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PAUSE_C     = 40000,
  parameter int unsigned REF_LOW_C   = 12,
  parameter int unsigned REF_PRE_C   = 8,
  parameter int unsigned SELF_LOW_C  = 20000,
  parameter int unsigned SELF_PRE_C  = 18,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  input  logic        wakeReq,
  output logic        cntZero,
  output logic        initLast,
  output logic        wakePend
);

  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;
  logic [INIT_W-1:0] initCnt;

  always_comb begin
    case (strobe.durSel)
      DUR_REF_LOW:  loadVal = CNT_W'(REF_LOW_C - 1);
      DUR_REF_PRE:  loadVal = CNT_W'(REF_PRE_C - 1);
      DUR_SELF_LOW: loadVal = CNT_W'(SELF_LOW_C - 1);
      DUR_SELF_PRE: loadVal = CNT_W'(SELF_PRE_C - 1);
      default:      loadVal = '0;
    endcase
  end

  // Reset value of PAUSE_C gives PAUSE_C full clocks after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= CNT_W'(PAUSE_C);
    else if (strobe.load)   cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  initCnt <= '0;
    else if (strobe.initClr)    initCnt <= '0;
    else if (strobe.initStep)   initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wakePend <= 1'b0;
    else if (strobe.wakeClr)              wakePend <= 1'b0;
    else if (strobe.wakeArm && wakeReq)   wakePend <= 1'b1;
  end

  assign cntZero  = (cnt == '0);
  assign initLast = (initCnt == INIT_W'(INIT_CYCLES - 1));

  // A latched wake survives until the control consumes it
  assert_wake_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wakePend && !strobe.wakeClr) |=> wakePend);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        wakeReq,
  input  logic        cntZero,
  input  logic        initLast,
  input  logic        wakePend,
  output seq_strobe_t strobe,
  output logic        rasN,
  output logic        casN,
  output logic        ready,
  output logic        sleeping
);

  seq_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobe.load     = 1'b0;
    strobe.durSel   = DUR_ONE;
    strobe.initStep = 1'b0;
    strobe.initClr  = 1'b0;
    strobe.wakeArm  = 1'b0;
    strobe.wakeClr  = 1'b0;
    case (state)
      ST_PAUSE: if (cntZero) begin
        nextState = ST_INIT_CAS; strobe.load = 1'b1; strobe.durSel = DUR_ONE;
      end
      ST_INIT_CAS: if (cntZero) begin
        nextState = ST_INIT_RAS; strobe.load = 1'b1; strobe.durSel = DUR_REF_LOW;
      end
      ST_INIT_RAS: if (cntZero) begin
        nextState = ST_INIT_PRE; strobe.load = 1'b1; strobe.durSel = DUR_REF_PRE;
      end
      ST_INIT_PRE: if (cntZero) begin
        strobe.initStep = 1'b1;
        if (initLast) begin
          nextState = ST_READY; strobe.initClr = 1'b1;
        end else begin
          nextState = ST_INIT_CAS; strobe.load = 1'b1; strobe.durSel = DUR_ONE;
        end
      end
      ST_READY: if (sleepReq) begin
        nextState = ST_ENT_CAS; strobe.load = 1'b1; strobe.durSel = DUR_ONE;
      end
      ST_ENT_CAS: if (cntZero) begin
        nextState = ST_SELF; strobe.load = 1'b1; strobe.durSel = DUR_SELF_LOW;
      end
      ST_SELF: begin
        strobe.wakeArm = 1'b1;
        if (cntZero && (wakePend || wakeReq)) begin
          nextState = ST_EXIT; strobe.load = 1'b1; strobe.durSel = DUR_SELF_PRE;
          strobe.wakeClr = 1'b1;
        end
      end
      ST_EXIT: if (cntZero) nextState = ST_READY;
      default: nextState = ST_PAUSE;
    endcase
  end

  assign rasN     = !(state == ST_INIT_RAS || state == ST_SELF);
  assign casN     = !(state == ST_INIT_CAS || state == ST_INIT_RAS ||
                      state == ST_ENT_CAS  || state == ST_SELF);
  assign ready    = (state == ST_READY);
  assign sleeping = (state == ST_SELF);

  assert_cas_leads_ras_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  assert_ready_strobes_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (rasN && casN));

  assert_init_complete_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ready) && $past(state) == ST_INIT_PRE) |-> $past(initLast));

  assert_self_min_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELF && !cntZero) |=> !rasN);

  assert_strobes_rise_together_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN));

endmodule

// File: rtl/dram_sleep_seq.sv
module dram_sleep_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned REF_LOW_NS    = 60,
  parameter int unsigned REF_PRE_NS    = 40,
  parameter int unsigned SELF_LOW_NS   = 100000,
  parameter int unsigned SELF_PRE_NS   = 90
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic rasN,
  output logic casN,
  output logic ready,
  output logic sleeping
);

  localparam int unsigned PAUSE_C    = nsToCycles(PAUSE_NS,    CLK_PERIOD_NS);
  localparam int unsigned REF_LOW_C  = nsToCycles(REF_LOW_NS,  CLK_PERIOD_NS);
  localparam int unsigned REF_PRE_C  = nsToCycles(REF_PRE_NS,  CLK_PERIOD_NS);
  localparam int unsigned SELF_LOW_C = nsToCycles(SELF_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned SELF_PRE_C = nsToCycles(SELF_PRE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_A      = (PAUSE_C > SELF_LOW_C) ? PAUSE_C : SELF_LOW_C;
  localparam int unsigned MAX_B      = (REF_LOW_C > REF_PRE_C) ? REF_LOW_C : REF_PRE_C;
  localparam int unsigned MAX_C      = (MAX_B > SELF_PRE_C) ? MAX_B : SELF_PRE_C;
  localparam int unsigned MAX_C_ALL  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int unsigned CNT_W      = $clog2(MAX_C_ALL + 1);

  seq_strobe_t strobe;
  logic cntZero, initLast, wakePend;

  dram_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .cntZero  (cntZero),
    .initLast (initLast),
    .wakePend (wakePend),
    .strobe   (strobe),
    .rasN     (rasN),
    .casN     (casN),
    .ready    (ready),
    .sleeping (sleeping)
  );

  dram_seq_timer #(
    .CNT_W       (CNT_W),
    .PAUSE_C     (PAUSE_C),
    .REF_LOW_C   (REF_LOW_C),
    .REF_PRE_C   (REF_PRE_C),
    .SELF_LOW_C  (SELF_LOW_C),
    .SELF_PRE_C  (SELF_PRE_C),
    .INIT_CYCLES (INIT_CYCLES)
  ) i_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wakeReq  (wakeReq),
    .cntZero  (cntZero),
    .initLast (initLast),
    .wakePend (wakePend)
  );

endmodule

// File: tb/test_dram_sleep_seq.sv
`timescale 1ns/1ps
module test_dram_sleep_seq;

  // Expected cycle counts from the requirements (R9): ceil(ns / 5)
  localparam int PAUSE_E    = (200000 + 4) / 5;
  localparam int REF_LOW_E  = (60 + 4) / 5;
  localparam int REF_PRE_E  = (40 + 4) / 5;
  localparam int SELF_LOW_E = (100000 + 4) / 5;
  localparam int SELF_PRE_E = (90 + 4) / 5;
  localparam int INIT_E     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0, sleepReq = 1'b0, wakeReq = 1'b0;
  logic rasN, casN, ready, sleeping;

  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dram_sleep_seq i_dram_sleep_seq (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .rasN(rasN), .casN(casN), .ready(ready), .sleeping(sleeping)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Behavioural reference: phase name plus remaining clocks in that phase
  string mPhase = "pause";
  int    mLeft = PAUSE_E, mDone = 0;
  bit    mWake = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = "pause"; mLeft = PAUSE_E; mDone = 0; mWake = 0;
    end else begin
      if (mPhase == "self" && wakeReq) mWake = 1;
      if (mPhase == "ready") begin
        if (sleepReq) begin mPhase = "entry"; mLeft = 0; end
      end else if (mLeft > 0) begin
        mLeft--;
      end else begin
        case (mPhase)
          "pause":   begin mPhase = "icas"; mLeft = 0; end
          "icas":    begin mPhase = "iras"; mLeft = REF_LOW_E - 1; end
          "iras":    begin mPhase = "ipre"; mLeft = REF_PRE_E - 1; end
          "ipre":    begin
            mDone++;
            if (mDone == INIT_E) mPhase = "ready";
            else begin mPhase = "icas"; mLeft = 0; end
          end
          "entry":   begin mPhase = "self"; mLeft = SELF_LOW_E - 1; end
          "self":    if (mWake) begin mPhase = "exit"; mLeft = SELF_PRE_E - 1; mWake = 0; end
          "exit":    mPhase = "ready";
          default:   ;
        endcase
      end
    end
  end

  // Monitors sampled on the falling edge
  int  pauseLen = 0, initFalls = 0, selfRun = 0, lastSelfLen = 0, preRun = 0, lastPreLen = 0;
  bit  casSeen = 0, everReady = 0, inPre = 0, prevRas = 1;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      finishRun();
    end
    if (!rstN) begin
      check("R1", "rasN in reset", rasN, 1);
      check("R1", "casN in reset", casN, 1);
      check("R1", "ready in reset", ready, 0);
      check("R1", "sleeping in reset", sleeping, 0);
    end else begin
      check("R1 R2 R6 R8", "rasN vs model", rasN,
            (mPhase == "iras" || mPhase == "self") ? 0 : 1);
      check("R2 R5", "casN vs model", casN,
            (mPhase == "icas" || mPhase == "iras" || mPhase == "entry" || mPhase == "self") ? 0 : 1);
      check("R3 R4 R8", "ready vs model", ready, (mPhase == "ready") ? 1 : 0);
      check("R5 R7", "sleeping vs model", sleeping, (mPhase == "self") ? 1 : 0);
      if (!casSeen) begin
        if (casN) pauseLen++; else casSeen = 1;
      end
      if (ready) everReady = 1;
      if (!everReady && prevRas && !rasN) initFalls++;
      if (everReady && !rasN) selfRun++;
      if (everReady && !prevRas && rasN) begin
        lastSelfLen = selfRun; selfRun = 0; inPre = 1; preRun = 0;
      end
      if (inPre) begin
        if (ready) begin lastPreLen = preRun; inPre = 0; end
        else preRun++;
      end
      prevRas = rasN;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitReady();
    while (!ready) @(negedge clk);
    #1;
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    // R4: requests during the pause are ignored
    tick(100);
    sleepReq = 1'b1; wakeReq = 1'b1;
    tick(3);
    sleepReq = 1'b0; wakeReq = 1'b0;
    waitReady();
    check("R9", "pause length in clocks", pauseLen, PAUSE_E);
    check("R2", "initialization row-strobe falls", initFalls, INIT_E);

    // R4: wake while ready does nothing
    tick(2);
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0;
    tick(5);
    check("R4", "ready after ignored wake", ready, 1);
    check("R4", "rasN after ignored wake", rasN, 1);

    // Late wake: exit follows the request
    sleepReq = 1'b1; tick(1); sleepReq = 1'b0;
    tick(2);
    check("R5", "sleeping after entry", sleeping, 1);
    tick(SELF_LOW_E + 500);
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0;
    waitReady();
    check("R6", "self low at least minimum", (lastSelfLen >= SELF_LOW_E) ? 1 : 0, 1);
    check("R8", "precharge clocks after late wake", lastPreLen, SELF_PRE_E);

    // Early wake: held pending until the minimum time ends
    tick(3);
    sleepReq = 1'b1; tick(1); sleepReq = 1'b0;
    tick(100);
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0;
    tick(50);
    check("R7", "still sleeping after early wake", sleeping, 1);
    waitReady();
    check("R7", "self low exactly minimum", lastSelfLen, SELF_LOW_E);
    check("R8", "precharge clocks after early wake", lastPreLen, SELF_PRE_E);
    tick(5);
    check("R3", "ready holds afterwards", ready, 1);
    finishRun();
  end

endmodule